// File: doc/BRIEF.md
# Dual-Bank Programmable Matrix Hash Index Unit

This block turns an IPv4 destination address into two cache set indices, one for each of two cache banks. Each index is a universal hash from the H3 class: every key bit selects one row of a boolean matrix, and all selected rows are combined with XOR. The two banks own separate matrices, so one address lands in two unrelated sets. A cache controller presents an address with a valid strobe and gets both indices one clock later.

The key is normally the sixteen middle address bits, address bits [23:8], because those vary the most across real traffic. A static configuration input can widen the key to all 32 address bits. Matrix rows are held in registers. They load built-in constants at reset, and a one-row-per-cycle write port can replace any row of either bank.

Top module: `h3_index_unit`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, out_valid is 0 and out_idx0 and out_idx1 are 0.
- R2: Reset loads row r (0..31) of bank 0 with ((2r+1)*157) mod 2^IDX_W and row r of bank 1 with ((2r+1)*59) mod 2^IDX_W.
- R3: With full_key low, out_idx_b is the XOR over r = 0..15 of row r of bank b, taking row r only when in_addr[8+r] is 1.
- R4: With full_key low, in_addr bits [7:0] and [31:24] and matrix rows 16..31 have no effect on either index.
- R5: With full_key high, out_idx_b is the XOR over r = 0..31 of row r of bank b, taking row r only when in_addr[r] is 1.
- R6: When wr_en is high at a clock edge, row wr_row of bank wr_bank (0 or 1) takes wr_data. Lookups presented from the next cycle on use the new row. No other row of either bank changes.
- R7: A lookup presented in the same cycle as a write uses the row value from before the write.
- R8: out_valid equals in_valid delayed by one cycle. Each index reflects the address and matrices sampled at that edge.
- R9: When in_valid is low, out_idx0 and out_idx1 keep their previous values.
- R10: A reset after row writes brings every row of both banks back to its R2 constant.
- R11: With full_key low, an address whose bits [23:8] are all zero yields index 0 in both banks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_key | input | 1 | Static mode: 1 selects the 32-bit key, 0 the 16-bit key |
| wr_en | input | 1 | Row write strobe |
| wr_bank | input | 1 | Bank the write targets |
| wr_row | input | 5 | Row number to write |
| wr_data | input | IDX_W | New row contents |
| in_valid | input | 1 | Lookup request valid |
| in_addr | input | 32 | Address to hash |
| out_valid | output | 1 | Indices valid, one cycle after in_valid |
| out_idx0 | output | IDX_W | Set index for bank 0 |
| out_idx1 | output | IDX_W | Set index for bank 1 |

## Verification
The hardest case to reach from the ports is a row write and a lookup landing on the same edge, together with proof that a write reached exactly one row of one bank. The stimulus walks a one-hot address across all 32 positions in full-key mode after each group of writes, so every row of both banks is read out on its own. It also issues a write at the same time as a lookup that selects the row being written, and expects the old value.

// File: rtl/h3_pkg.sv
package h3_pkg;
    localparam int ADDR_W = 32;
    localparam int ROW_W  = $clog2(ADDR_W);
    localparam int KEY_LO = 8;
    localparam int KEY_W  = 16;
    localparam int NBANK  = 2;

    localparam int MULT_B0 = 157;
    localparam int MULT_B1 = 59;

    function automatic logic [31:0] default_row(input int bank, input int row);
        int mult;
        mult = (bank == 0) ? MULT_B0 : MULT_B1;
        return 32'((2 * row + 1) * mult);
    endfunction
endpackage

// File: rtl/h3_row_store.sv
module h3_row_store
    import h3_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int BANK  = 0
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en_i,
    input  logic [ROW_W-1:0]               wr_row_i,
    input  logic [IDX_W-1:0]               wr_data_i,
    output logic [ADDR_W-1:0][IDX_W-1:0]   rows_o
);
    logic [ADDR_W-1:0][IDX_W-1:0] rows_d, rows_q;

    always_comb begin
        rows_d = rows_q;
        if (wr_en_i) begin
            rows_d[wr_row_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ADDR_W; r++) begin
                rows_q[r] <= IDX_W'(default_row(BANK, r));
            end
        end else begin
            rows_q <= rows_d;
        end
    end

    assign rows_o = rows_q;

    // R6: a write lands in the addressed row
    assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> rows_q[$past(wr_row_i)] == $past(wr_data_i));

    // R6: without a write to this bank the matrix is untouched
    assert_rows_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(rows_q));
endmodule

// File: rtl/h3_hash_core.sv
module h3_hash_core
    import h3_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic                            full_key_i,
    input  logic [ADDR_W-1:0][IDX_W-1:0]    rows_i,
    output logic [IDX_W-1:0]                idx_o
);
    logic [ADDR_W-1:0] gate;

    generate
        for (genvar r = 0; r < ADDR_W; r++) begin : g_gate
            if (r < KEY_W) begin : g_key
                assign gate[r] = full_key_i ? addr_i[r] : addr_i[KEY_LO + r];
            end else begin : g_wide
                assign gate[r] = full_key_i & addr_i[r];
            end
        end
    endgenerate

    always_comb begin
        idx_o = '0;
        for (int r = 0; r < ADDR_W; r++) begin
            idx_o = idx_o ^ (rows_i[r] & {IDX_W{gate[r]}});
        end
    end
endmodule

// File: rtl/h3_index_unit.sv
module h3_index_unit
    import h3_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              full_key,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [IDX_W-1:0]  wr_data,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    output logic [IDX_W-1:0]  out_idx0,
    output logic [IDX_W-1:0]  out_idx1
);
    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx0;
        logic [IDX_W-1:0] idx1;
    } out_t;

    logic [ADDR_W-1:0][IDX_W-1:0] rows   [NBANK];
    logic [IDX_W-1:0]             idx_c  [NBANK];

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            h3_row_store #(.IDX_W(IDX_W), .BANK(b)) u_store (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en_i  (wr_en && (wr_bank == 1'(b))),
                .wr_row_i (wr_row),
                .wr_data_i(wr_data),
                .rows_o   (rows[b])
            );
            h3_hash_core #(.IDX_W(IDX_W)) u_hash (
                .addr_i    (in_addr),
                .full_key_i(full_key),
                .rows_i    (rows[b]),
                .idx_o     (idx_c[b])
            );
        end
    endgenerate

    out_t out_d, out_q;

    always_comb begin
        out_d       = out_q;
        out_d.valid = in_valid;
        if (in_valid) begin
            out_d.idx0 = idx_c[0];
            out_d.idx1 = idx_c[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid = out_q.valid;
    assign out_idx0  = out_q.idx0;
    assign out_idx1  = out_q.idx1;

    // R8: valid follows the request by one cycle
    assert_valid_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9: indices hold while no request is present
    assert_idx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_idx0) && $stable(out_idx1)));

    // R11: an all-zero 16-bit key hashes to zero in both banks
    assert_zero_key_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !full_key && (in_addr[KEY_LO+KEY_W-1:KEY_LO] == '0))
        |=> (out_idx0 == '0 && out_idx1 == '0));
endmodule

// File: tb/h3_index_unit_test.sv
`timescale 1ns/1ps
module h3_index_unit_test;
    localparam int J = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         full_key;
    logic         wr_en;
    logic         wr_bank;
    logic [4:0]   wr_row;
    logic [J-1:0] wr_data;
    logic         in_valid;
    logic [31:0]  in_addr;
    logic         out_valid;
    logic [J-1:0] out_idx0, out_idx1;

    int n_cmp = 0;
    int n_bad = 0;
    logic [J-1:0] m [2][32];
    logic [31:0]  seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    h3_index_unit #(.IDX_W(J)) uut (
        .clk(clk), .rst_n(rst_n), .full_key(full_key),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_row(wr_row), .wr_data(wr_data),
        .in_valid(in_valid), .in_addr(in_addr),
        .out_valid(out_valid), .out_idx0(out_idx0), .out_idx1(out_idx1)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic logic [J-1:0] model(input int b, input logic [31:0] a, input logic fk);
        logic [J-1:0] acc = '0;
        for (int r = 0; r < 32; r++) begin
            if (fk) begin
                if (a[r]) acc = acc ^ m[b][r];
            end else if (r < 16) begin
                if (a[8 + r]) acc = acc ^ m[b][r];
            end
        end
        return acc;
    endfunction

    task automatic load_defaults();
        for (int r = 0; r < 32; r++) begin
            m[0][r] = J'((2 * r + 1) * 157);
            m[1][r] = J'((2 * r + 1) * 59);
        end
    endtask

    // leaves in_valid high so calls can be chained back to back
    task automatic lookup(input logic [31:0] a, input string req);
        logic [J-1:0] e0, e1;
        e0 = model(0, a, full_key);
        e1 = model(1, a, full_key);
        in_valid = 1'b1;
        in_addr  = a;
        @(negedge clk);
        chk({req, " R8 valid"}, 32'(out_valid), 32'd1);
        chk({req, " idx0"}, 32'(out_idx0), 32'(e0));
        chk({req, " idx1"}, 32'(out_idx1), 32'(e1));
    endtask

    task automatic write_row(input logic b, input int r, input logic [J-1:0] d);
        wr_en = 1'b1; wr_bank = b; wr_row = 5'(r); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        m[b][r] = d;
    endtask

    task automatic walk_rows(input string req);
        full_key = 1'b1;
        for (int r = 0; r < 32; r++) lookup(32'd1 << r, req);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", 32'(out_valid), 32'd0);
        chk("R1 idx0 in reset", 32'(out_idx0), 32'd0);
        chk("R1 idx1 in reset", 32'(out_idx1), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", 32'(out_valid), 32'd0);
        chk("R1 idx0 after reset", 32'(out_idx0), 32'd0);
        load_defaults();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [J-1:0] h0, h1;
        logic [31:0]  a;
        rst_n = 1'b0; full_key = 1'b0; wr_en = 1'b0; wr_bank = 1'b0;
        wr_row = '0; wr_data = '0; in_valid = 1'b0; in_addr = '0;
        @(negedge clk);
        do_reset();

        // R2 and R5: every default row read out by a one-hot full key
        walk_rows("R2 R5 default row");

        // R3 and R4: one-hot addresses in 16-bit mode
        full_key = 1'b0;
        for (int r = 0; r < 32; r++) lookup(32'd1 << r, "R3 R4 one-hot 16b");

        // R3 and R4: pseudo-random addresses in 16-bit mode, back to back
        for (int i = 0; i < 300; i++) lookup(rnd(), "R3 R4 random 16b");
        in_valid = 1'b0;
        @(negedge clk);
        chk("R8 valid drops", 32'(out_valid), 32'd0);

        // R4: bits outside [23:8] leave the index unchanged
        a = rnd();
        lookup(a & 32'h00FF_FF00, "R4 masked");
        h0 = out_idx0; h1 = out_idx1;
        lookup(a | 32'hFF00_00FF, "R4 outer bits set");
        chk("R4 bank0 outer bits ignored", 32'(out_idx0), 32'(h0));
        chk("R4 bank1 outer bits ignored", 32'(out_idx1), 32'(h1));

        // R11: all-zero 16-bit key
        lookup(32'hFF00_00FF, "R11 zero key");
        chk("R11 idx0 zero", 32'(out_idx0), 32'd0);

        // R5: pseudo-random addresses in 32-bit mode
        in_valid = 1'b0;
        @(negedge clk);
        full_key = 1'b1;
        for (int i = 0; i < 300; i++) lookup(rnd(), "R5 random 32b");

        // R9: indices hold while idle with a changing address
        h0 = out_idx0; h1 = out_idx1;
        in_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            in_addr = rnd();
            @(negedge clk);
            chk("R9 idx0 hold", 32'(out_idx0), 32'(h0));
            chk("R9 idx1 hold", 32'(out_idx1), 32'(h1));
            chk("R8 idle valid", 32'(out_valid), 32'd0);
        end

        // R6: row writes, each observed alone, then a full walk
        for (int i = 0; i < 24; i++) begin
            logic b;
            int   r;
            b = 1'(rnd());
            r = int'(rnd() % 32);
            write_row(b, r, J'(rnd()));
            full_key = 1'b1;
            lookup(32'd1 << r, "R6 written row");
            in_valid = 1'b0;
        end
        @(negedge clk);
        walk_rows("R6 walk after writes");

        // R4: rows 16..31 are unused in 16-bit mode even when rewritten
        full_key = 1'b0;
        for (int i = 0; i < 40; i++) lookup(rnd(), "R4 R3 after writes 16b");
        in_valid = 1'b0;
        @(negedge clk);

        // R7: write and lookup on the same edge see the old row
        full_key = 1'b1;
        for (int i = 0; i < 8; i++) begin
            logic [J-1:0] e0, e1, nd;
            int r;
            logic b;
            r  = int'(rnd() % 32);
            b  = 1'(i);
            nd = ~m[b][r];
            e0 = model(0, 32'd1 << r, 1'b1);
            e1 = model(1, 32'd1 << r, 1'b1);
            wr_en = 1'b1; wr_bank = b; wr_row = 5'(r); wr_data = nd;
            in_valid = 1'b1; in_addr = 32'd1 << r;
            @(negedge clk);
            wr_en = 1'b0;
            chk("R7 idx0 old row", 32'(out_idx0), 32'(e0));
            chk("R7 idx1 old row", 32'(out_idx1), 32'(e1));
            m[b][r] = nd;
            lookup(32'd1 << r, "R7 new row next cycle");
            in_valid = 1'b0;
        end
        @(negedge clk);

        // R10: reset restores every default row
        do_reset();
        walk_rows("R10 defaults restored");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule